// File: doc/BRIEF.md
# I2C Memory Slave Protocol Engine

This block is the bus-facing half of a serial memory slave. It runs on a fast system clock and oversamples the two-wire bus lines (SCL, SDA). It finds START and STOP conditions on the resynchronised lines and shifts in the device address byte, which must match a fixed 7-bit address. It acknowledges by pulling SDA low through an open-drain output enable. It then steps through the write and read transaction types of a byte-addressed memory. Supported transactions are single-byte write, multi-byte (page) write, current-address read, random read (a write addressing phase followed by a repeated START), and sequential read.

The engine keeps no address counter and no storage. A separate address/page-buffer block holds those. When the first byte of a write arrives, the engine pulses a word-address strobe with the byte on a shared bus. Each later write byte gets a data strobe. A STOP that ends a write carrying data gets a single commit pulse. For reads, the neighbour presents the byte at its current pointer. The engine latches that byte when it starts to send it and pulses an advance strobe so the neighbour moves on.

Top module: `i2cs_engine`

## Requirements
- R1: A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. Both are detected on the synchronised lines. An SDA change while SCL is high is never shifted in as a data bit.
- R2: The address byte is received MSB first. Its upper seven bits must equal `DEV_ADDR` (default 1010000), and bit 0 selects read (1) or write (0). On a mismatch the engine does not acknowledge and ignores all bits until the next START or STOP.
- R3: After a matched address byte, and after each byte received in a write, the engine holds `sda_oe` high for the whole ninth clock. The acknowledge is seen as SDA low while SCL is high.
- R4: In a write, the first byte after the address produces a one-cycle `addr_stb` with the byte on `rx_byte`. Every later byte produces a one-cycle `data_stb`. At most one of `addr_stb`, `data_stb`, `rd_adv` and `commit` is high in any cycle.
- R5: `sda_oe` changes only while SCL is low, apart from the release caused by START or STOP.
- R6: In a read, the engine sends the byte on `rd_data` MSB first, with a 1 meaning SDA released. It pulses `rd_adv` once as each byte is loaded. It sends another byte only when the master acknowledges.
- R7: On a master NACK the engine releases SDA and drives nothing until the next START or STOP.
- R8: A START at any point abandons the current transaction and restarts address reception. A repeated START after the write addressing phase therefore turns into a random read from the loaded address.
- R9: A STOP that follows at least one accepted write data byte gives a one-cycle `commit`. A STOP after only an address phase, a read, or an unmatched address gives none.
- R10: While `rst` is high, `sda_oe`, `addr_stb`, `data_stb`, `rd_adv` and `commit` are all low, and the engine waits for a START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| rx_byte | output | 8 | Last received word-address or data byte |
| addr_stb | output | 1 | One-cycle pulse: `rx_byte` holds a word address |
| data_stb | output | 1 | One-cycle pulse: `rx_byte` holds a write data byte |
| rd_data | input | 8 | Byte at the neighbour's current pointer |
| rd_adv | output | 1 | One-cycle pulse: `rd_data` was taken, advance the pointer |
| commit | output | 1 | One-cycle pulse: write with data closed by STOP |

## Verification
The bench builds the engine with its defaults: device address 1010000 and a two-stage synchroniser. With these, the matching address 0xA0/0xA1 can be contrasted with 0xA2, which differs only in the lowest address bit. The three-cycle edge latency stays well inside the bench's SCL low phase of eight system clocks, so the timing of `sda_oe` against SCL can be observed directly on the wire. A memory model in the bench plays the neighbour. With it, random, sequential and current-address reads return values that follow from earlier writes. The bench also covers a START inside a write data byte and STOPs both with and without data.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    localparam cnt_t CNT_FULL = cnt_t'(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_WAIT
    } state_e;

    typedef enum logic [1:0] {
        K_DEV,
        K_WADR,
        K_WDATA
    } kind_e;

    typedef struct packed {
        state_e st;
        kind_e  kind;
        logic   rw;
        cnt_t   cnt;
        logic   mack;
        logic   got_data;
    } ctl_t;

    function automatic logic dev_match(input byte_t b, input logic [6:0] a);
        return b[BYTE_W-1:1] == a;
    endfunction

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] r;

    always_ff @(posedge clk) begin
        if (rst) r <= '1;
        else     r <= {r[STAGES-2:0], d};
    end

    assign q = r[STAGES-1];
endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond (
    input  logic clk,
    input  logic rst,
    input  logic s_scl,
    input  logic s_sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);
    logic p_scl, p_sda;

    always_ff @(posedge clk) begin
        if (rst) begin
            p_scl <= 1'b1;
            p_sda <= 1'b1;
        end else begin
            p_scl <= s_scl;
            p_sda <= s_sda;
        end
    end

    assign scl_rise = s_scl & ~p_scl;
    assign scl_fall = ~s_scl & p_scl;
    assign start_c  = p_scl & s_scl & p_sda & ~s_sda;
    assign stop_c   = p_scl & s_scl & ~p_sda & s_sda;
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
    import i2cs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b1010000,
    parameter int         SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    output logic [7:0]  rx_byte,
    output logic        addr_stb,
    output logic        data_stb,
    input  logic [7:0]  rd_data,
    output logic        rd_adv,
    output logic        commit
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw, syn;
    logic s_scl, s_sda;
    logic scl_rise, scl_fall, start_c, stop_c;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_sync
        i2cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (raw[g]),
            .q   (syn[g])
        );
    end

    assign s_scl = syn[1];
    assign s_sda = syn[0];

    i2cs_cond u_cond (
        .clk      (clk),
        .rst      (rst),
        .s_scl    (s_scl),
        .s_sda    (s_sda),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_c  (start_c),
        .stop_c   (stop_c)
    );

    ctl_t  c;
    byte_t sh, tx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            c        <= '{st: ST_IDLE, kind: K_DEV, rw: 1'b0, cnt: '0, mack: 1'b0, got_data: 1'b0};
            sh       <= '0;
            tx_sh    <= '0;
            sda_oe   <= 1'b0;
            rx_byte  <= '0;
            addr_stb <= 1'b0;
            data_stb <= 1'b0;
            rd_adv   <= 1'b0;
            commit   <= 1'b0;
        end else begin
            addr_stb <= 1'b0;
            data_stb <= 1'b0;
            rd_adv   <= 1'b0;
            commit   <= 1'b0;
            if (start_c) begin
                c.st   <= ST_RX;
                c.kind <= K_DEV;
                c.cnt  <= '0;
                c.mack <= 1'b0;
                sda_oe <= 1'b0;
            end else if (stop_c) begin
                c.st       <= ST_IDLE;
                sda_oe     <= 1'b0;
                commit     <= c.got_data;
                c.got_data <= 1'b0;
            end else begin
                unique case (c.st)
                    ST_RX: begin
                        if (scl_rise) begin
                            sh    <= {sh[BYTE_W-2:0], s_sda};
                            c.cnt <= c.cnt + 1'b1;
                        end else if (scl_fall && c.cnt == CNT_FULL) begin
                            c.cnt <= '0;
                            unique case (c.kind)
                                K_DEV: begin
                                    if (dev_match(sh, DEV_ADDR)) begin
                                        c.rw   <= sh[0];
                                        sda_oe <= 1'b1;
                                        c.st   <= ST_ACK;
                                    end else begin
                                        c.st   <= ST_WAIT;
                                    end
                                end
                                K_WADR: begin
                                    rx_byte  <= sh;
                                    addr_stb <= 1'b1;
                                    sda_oe   <= 1'b1;
                                    c.st     <= ST_ACK;
                                end
                                default: begin
                                    rx_byte    <= sh;
                                    data_stb   <= 1'b1;
                                    c.got_data <= 1'b1;
                                    sda_oe     <= 1'b1;
                                    c.st       <= ST_ACK;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            c.cnt <= '0;
                            if (c.kind == K_DEV && c.rw) begin
                                tx_sh  <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                                rd_adv <= 1'b1;
                                c.st   <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                c.st   <= ST_RX;
                                c.kind <= (c.kind == K_DEV) ? K_WADR : K_WDATA;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            c.cnt <= c.cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (c.cnt == CNT_FULL) begin
                                sda_oe <= 1'b0;
                                c.mack <= 1'b0;
                                c.st   <= ST_MACK;
                            end else begin
                                tx_sh  <= tx_sh << 1;
                                sda_oe <= ~tx_sh[BYTE_W-2];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            if (s_sda) c.st   <= ST_WAIT;
                            else       c.mack <= 1'b1;
                        end else if (scl_fall && c.mack) begin
                            c.cnt  <= '0;
                            tx_sh  <= rd_data;
                            sda_oe <= ~rd_data[BYTE_W-1];
                            rd_adv <= 1'b1;
                            c.st   <= ST_TX;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_OE_LOW_PHASE: assert property (@(posedge clk) disable iff (rst)
        (s_scl && !$past(start_c || stop_c)) |-> $stable(sda_oe)); // R5

    AST_STB_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({addr_stb, data_stb, rd_adv, commit})); // R4

    AST_COMMIT_ON_STOP: assert property (@(posedge clk) disable iff (rst)
        commit |-> $past(stop_c)); // R9

    AST_START_RESTART: assert property (@(posedge clk) disable iff (rst)
        start_c |=> (c.st == ST_RX && c.cnt == '0 && !sda_oe)); // R8

    AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (c.st == ST_WAIT) |-> !sda_oe); // R7

endmodule

// File: tb/i2cs_engine_bench.sv
module i2cs_engine_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe, addr_stb, data_stb, rd_adv, commit;
    logic [7:0] rx_byte, rd_data;
    logic sda_line;

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2cs_engine u_i2cs_engine (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .rx_byte  (rx_byte),
        .addr_stb (addr_stb),
        .data_stb (data_stb),
        .rd_data  (rd_data),
        .rd_adv   (rd_adv),
        .commit   (commit)
    );

    // neighbour model: pointer plus byte array
    logic [7:0] mem [256];
    logic [7:0] ptr;
    assign rd_data = mem[ptr];

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h3C;
        ptr = 8'h00;
    end

    always @(posedge clk) begin
        if (addr_stb) ptr <= rx_byte;
        else if (data_stb) begin
            mem[ptr] <= rx_byte;
            ptr <= ptr + 8'd1;
        end else if (rd_adv) ptr <= ptr + 8'd1;
    end

    int checks = 0;
    int errors = 0;
    int commits = 0;
    int r5_bad = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard: kind 1 = word address, 2 = data, 3 = commit
    logic [9:0] exp_q [$];

    task automatic push(input logic [1:0] k, input logic [7:0] v);
        exp_q.push_back({k, v});
    endtask

    task automatic observe(input logic [1:0] k, input logic [7:0] v, input string req);
        logic [9:0] e;
        if (exp_q.size() == 0) begin
            chk(1'b0, req, {k, v}, 0);
        end else begin
            e = exp_q.pop_front();
            chk(e == {k, v}, req, {k, v}, e);
        end
    endtask

    logic prev_oe = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (addr_stb) observe(2'd1, rx_byte, "R4 addr_stb");
            if (data_stb) observe(2'd2, rx_byte, "R4 data_stb");
            if (commit) begin
                commits++;
                observe(2'd3, 8'h00, "R9 commit");
            end
            if (sda_oe != prev_oe && scl_m) r5_bad++;
        end
        prev_oe = sda_oe;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start();
        sda_m = 1'b1; tick(3);
        scl_m = 1'b1; tick(6);
        sda_m = 1'b0; tick(6);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic do_stop();
        sda_m = 1'b0; tick(3);
        scl_m = 1'b1; tick(6);
        sda_m = 1'b1; tick(10);
    endtask

    task automatic clk_bit(input logic b, output logic seen);
        sda_m = b; tick(6);
        scl_m = 1'b1; tick(5);
        seen = sda_line; tick(5);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
        clk_bit(1'b1, s);
        acked = !s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        logic s;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, s);
            v = {v[6:0], s};
        end
        clk_bit(!give_ack, s);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic a;
        logic [7:0] v;
        int c0;

        tick(4);
        chk(!sda_oe && !addr_stb && !data_stb && !rd_adv && !commit, "R10 reset quiet",
            {sda_oe, addr_stb, data_stb, rd_adv, commit}, 0);
        rst = 1'b0;
        tick(10);

        // byte write
        push(2'd1, 8'h12); push(2'd2, 8'hA5); push(2'd3, 8'h00);
        do_start();
        send_byte(8'hA0, a); chk(a, "R2 R3 address ack", a, 1);
        send_byte(8'h12, a); chk(a, "R3 word address ack", a, 1);
        send_byte(8'hA5, a); chk(a, "R3 data ack", a, 1);
        do_stop();

        // page write of three bytes
        push(2'd1, 8'h40); push(2'd2, 8'h11); push(2'd2, 8'h22); push(2'd2, 8'h33); push(2'd3, 8'h00);
        do_start();
        send_byte(8'hA0, a);
        send_byte(8'h40, a);
        send_byte(8'h11, a);
        send_byte(8'h22, a);
        send_byte(8'h33, a); chk(a, "R3 page data ack", a, 1);
        do_stop();

        // unmatched address: 1010001
        c0 = commits;
        do_start();
        send_byte(8'hA2, a); chk(!a, "R2 mismatch no ack", a, 0);
        send_byte(8'h55, a); chk(!a, "R2 ignored byte no ack", a, 0);
        do_stop();
        chk(commits == c0, "R9 no commit after mismatch", commits, c0);

        // address phase only, then STOP
        push(2'd1, 8'h50);
        c0 = commits;
        do_start();
        send_byte(8'hA0, a);
        send_byte(8'h50, a);
        do_stop();
        tick(4);
        chk(commits == c0, "R9 no commit after address only", commits, c0);

        // random read of 0x12 via repeated START, then NACK
        push(2'd1, 8'h12);
        do_start();
        send_byte(8'hA0, a);
        send_byte(8'h12, a);
        do_start();
        send_byte(8'hA1, a); chk(a, "R8 read address ack after repeated START", a, 1);
        recv_byte(1'b0, v); chk(v == 8'hA5, "R6 R8 random read data", v, 8'hA5);
        recv_byte(1'b0, v); chk(v == 8'hFF, "R7 released after NACK", v, 8'hFF);
        do_stop();

        // sequential read from 0x40
        push(2'd1, 8'h40);
        do_start();
        send_byte(8'hA0, a);
        send_byte(8'h40, a);
        do_start();
        send_byte(8'hA1, a);
        recv_byte(1'b1, v); chk(v == 8'h11, "R6 sequential byte 0", v, 8'h11);
        recv_byte(1'b1, v); chk(v == 8'h22, "R6 sequential byte 1", v, 8'h22);
        recv_byte(1'b0, v); chk(v == 8'h33, "R6 sequential byte 2", v, 8'h33);
        do_stop();

        // current-address read continues at 0x43
        c0 = commits;
        do_start();
        send_byte(8'hA1, a); chk(a, "R2 read select ack", a, 1);
        recv_byte(1'b0, v); chk(v == (8'h43 ^ 8'h3C), "R6 current address read", v, 8'h43 ^ 8'h3C);
        do_stop();
        chk(commits == c0, "R9 no commit after read", commits, c0);

        // START inside a data byte aborts; SDA moves with SCL high are not data
        push(2'd1, 8'h60); push(2'd1, 8'h61); push(2'd2, 8'h77); push(2'd3, 8'h00);
        do_start();
        send_byte(8'hA0, a);
        send_byte(8'h60, a);
        clk_bit(1'b1, a); clk_bit(1'b0, a); clk_bit(1'b1, a); clk_bit(1'b0, a);
        do_start();
        send_byte(8'hA0, a); chk(a, "R1 R8 address ack after abort", a, 1);
        send_byte(8'h61, a);
        send_byte(8'h77, a); chk(a, "R8 data ack after abort", a, 1);
        do_stop();
        tick(4);

        chk(exp_q.size() == 0, "R4 R9 scoreboard drained", exp_q.size(), 0);
        chk(r5_bad == 0, "R5 sda_oe steady while SCL high", r5_bad, 0);
        chk(mem[8'h61] == 8'h77, "R4 write reached neighbour", mem[8'h61], 8'h77);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule